// File: doc/BRIEF.md
# Serial Port Control and Interrupt Register Block

This block is the software-visible face of a serial port whose transmit and receive FIFOs each hold 16 characters. A simple register bus (byte address, write data, write strobe, read strobe, combinational read data) reaches eight registers:

- a character data port;
- a sticky receive-error register;
- the line format and control settings;
- a read-only flag word;
- the pending-interrupt register;
- two programmable FIFO thresholds.

The line format and control fields drive the serial core directly. The core in turn supplies the FIFO fill counts, error pulses, a receive-timeout pulse, the modem inputs and a busy level.

The interrupt logic turns FIFO fill levels, modem changes and timeouts into four pending bits. Each bit can only be set while its enable is on. A write of any value to the pending register clears all four bits. A level condition that still holds sets its bit again on the following clock. The interrupt output is high while any bit is pending. The serial shifter and the baud generator sit outside this block.

Top module: `serial_csr_top`

## Requirements
- R1: After reset:
  - line control, control, error status and pending bits read 0;
  - the receive threshold reads 1 and the transmit threshold reads 0;
  - `irqOut` is low.
- R2: Line control (byte 0x08) stores bits 6:0 and reads bit 7 as 0. Its bits drive the outputs: break bit 0, parity enable bit 1, even parity bit 2, two stop bits bit 3, FIFO enable bit 4, word length bits 6:5 (0 means 5 bits, 3 means 8 bits).
- R3: Control (byte 0x14) stores bits 0 and 7:3, and bits 2:1 read 0. Bit 0 drives `uartEn` and bit 7 drives `loopback`. The interrupt enables are: bit 3 modem, bit 4 receive, bit 5 transmit, bit 6 timeout.
- R4: Data port (byte 0x00):
  - a write pulses `txPush` for that cycle with `txData` equal to the write data;
  - a read returns `rxData` and pulses `rxPop` for that cycle;
  - `rxPop` stays low for a read of any other address.
- R5: The flag word (byte 0x18) is built from these bits:
  - bits 0, 1, 2: CTS, DSR, DCD after a two-flop synchroniser;
  - bit 3: `busyIn`;
  - bit 4: receive count is 0;
  - bit 5: transmit count is 16;
  - bit 6: receive count is 16;
  - bit 7: transmit count is 0.
- R6: Error status (byte 0x04) captures one-cycle error pulses as sticky bits: framing bit 0, parity bit 1, break bit 2, overrun bit 3. A write of any value clears all of them. A write clear wins over a pulse in the same cycle.
- R7: Pending bit 1 is set when the receive count is at or above the receive threshold (byte 0x38) while receive enable is set.
- R8: Pending bit 2 is set when the transmit count is at or below the transmit threshold (byte 0x3C) while transmit enable is set.
- R9: Pending bit 0 is set one clock after any change of synchronised CTS while the modem enable is set.
- R10: Pending bit 3 is set by a receive-timeout pulse while the timeout enable is set.
- R11: An event that occurs while its enable is clear sets no pending bit, and turning the enable on later does not recover a past pulse event.
- R12: A write of any value to the pending register (byte 0x1C) clears all four bits. A level condition that still holds sets its bit again on the next clock.
- R13: `irqOut` is high exactly when at least one pending bit is set.
- R14: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Register byte address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busRdata | output | 8 | Read data, valid in the cycle of the address |
| txPush | output | 1 | Push a character into the transmit FIFO |
| txData | output | 8 | Character pushed |
| rxPop | output | 1 | Pop the receive FIFO head |
| rxData | input | 8 | Receive FIFO head |
| rxCount | input | 5 | Receive FIFO fill count, 0 to 16 |
| txCount | input | 5 | Transmit FIFO fill count, 0 to 16 |
| errFrame | input | 1 | Framing error pulse |
| errParity | input | 1 | Parity error pulse |
| errBreak | input | 1 | Break detected pulse |
| errOverrun | input | 1 | Overrun pulse |
| rxTimeout | input | 1 | Receive timeout pulse |
| ctsIn | input | 1 | Asynchronous clear-to-send |
| dsrIn | input | 1 | Asynchronous data-set-ready |
| dcdIn | input | 1 | Asynchronous carrier detect |
| busyIn | input | 1 | Transmitter busy |
| brkOut | output | 1 | Hold line in break |
| parityEn | output | 1 | Parity enabled |
| parityEven | output | 1 | Even parity selected |
| twoStop | output | 1 | Two stop bits |
| fifoEn | output | 1 | FIFOs enabled |
| wordLen | output | 2 | Word length minus 5 |
| uartEn | output | 1 | Port enable |
| loopback | output | 1 | Internal loopback |
| irqOut | output | 1 | Interrupt request |

## Verification
The threshold comparisons are swept over every receive level and count from 0 to 16, and over several transmit levels. A comparator that is off by one or compares the wrong way sets the pending bit one count early or late at the boundary, and the sweep catches that.

Each sweep step first clears the pending register and reads 0, then reads again one clock later. A design that leaves the bit cleared fails the re-arm check. A design that ignores the clear fails the zero check.

The modem path is sampled on the exact clocks that two synchroniser stages and the edge detector imply, so an added or missing stage shows up as early or late data. Error and timeout pulses are also applied while their enable is off, in the same cycle as a clear, and to unmapped addresses. This exposes a design that lets an ungated or overlapping event slip through.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] ADDR_DATA  = 6'h00;
  localparam logic [REG_AW-1:0] ADDR_STAT  = 6'h04;
  localparam logic [REG_AW-1:0] ADDR_LINE  = 6'h08;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 6'h14;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 6'h18;
  localparam logic [REG_AW-1:0] ADDR_INTID = 6'h1C;
  localparam logic [REG_AW-1:0] ADDR_RXLVL = 6'h38;
  localparam logic [REG_AW-1:0] ADDR_TXLVL = 6'h3C;

  localparam logic [7:0] LINE_WMASK = 8'h7F;
  localparam logic [7:0] CTRL_WMASK = 8'hF9;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_MSIE  = 3;
  localparam int CTRL_RXIE  = 4;
  localparam int CTRL_TXIE  = 5;
  localparam int CTRL_TOIE  = 6;
  localparam int CTRL_LOOP  = 7;

  localparam int INT_MODEM = 0;
  localparam int INT_RX    = 1;
  localparam int INT_TX    = 2;
  localparam int INT_TMO   = 3;

  localparam int MODEM_N = 3;

  typedef struct packed {
    logic wrData;
    logic wrStat;
    logic wrLine;
    logic wrCtrl;
    logic wrIntId;
    logic wrRxLvl;
    logic wrTxLvl;
    logic rdData;
  } csrStrobe_t;

endpackage

// File: rtl/serial_csr_ctrl.sv
module serial_csr_ctrl
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic [REG_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] rxData,
  input  logic [7:0]        lineQ,
  input  logic [7:0]        ctrlQ,
  input  logic [3:0]        errStat,
  input  logic [7:0]        flagsQ,
  input  logic [3:0]        intPend,
  input  logic [CNT_W-1:0]  rxLvlQ,
  input  logic [CNT_W-1:0]  txLvlQ,
  output csrStrobe_t        strb,
  output logic [DATA_W-1:0] busRdata
);

  always_comb begin
    strb = '0;
    if (busWe) begin
      case (busAddr)
        ADDR_DATA:  strb.wrData  = 1'b1;
        ADDR_STAT:  strb.wrStat  = 1'b1;
        ADDR_LINE:  strb.wrLine  = 1'b1;
        ADDR_CTRL:  strb.wrCtrl  = 1'b1;
        ADDR_INTID: strb.wrIntId = 1'b1;
        ADDR_RXLVL: strb.wrRxLvl = 1'b1;
        ADDR_TXLVL: strb.wrTxLvl = 1'b1;
        default:    ;
      endcase
    end
    if (busRe && (busAddr == ADDR_DATA)) strb.rdData = 1'b1;
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA:  busRdata = rxData;
      ADDR_STAT:  busRdata = DATA_W'(errStat);
      ADDR_LINE:  busRdata = DATA_W'(lineQ);
      ADDR_CTRL:  busRdata = DATA_W'(ctrlQ);
      ADDR_FLAG:  busRdata = DATA_W'(flagsQ);
      ADDR_INTID: busRdata = DATA_W'(intPend);
      ADDR_RXLVL: busRdata = DATA_W'(rxLvlQ);
      ADDR_TXLVL: busRdata = DATA_W'(txLvlQ);
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/serial_csr_dp.sv
module serial_csr_dp
  import serial_csr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RX_LVL_RST  = 1,
  parameter int TX_LVL_RST  = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  csrStrobe_t         strb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [3:0]         errIn,
  input  logic               rxTimeout,
  input  logic [MODEM_N-1:0] modemIn,
  input  logic               busyIn,
  output logic [7:0]         lineQ,
  output logic [7:0]         ctrlQ,
  output logic [3:0]         errStat,
  output logic [7:0]         flagsQ,
  output logic [3:0]         intPend,
  output logic [CNT_W-1:0]   rxLvlQ,
  output logic [CNT_W-1:0]   txLvlQ,
  output logic               irqOut,
  output logic               txPush,
  output logic [DATA_W-1:0]  txData,
  output logic               rxPop
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [MODEM_N-1:0] modemSync;
  logic               ctsPrev;
  logic               ctsChange;
  logic               rxHigh;
  logic               txLow;
  logic [3:0]         intSet;

  // Two or more flops per asynchronous modem input
  for (genvar g = 0; g < MODEM_N; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], modemIn[g]};
    end
    assign modemSync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctsPrev <= 1'b0;
    else       ctsPrev <= modemSync[0];
  end

  assign ctsChange = modemSync[0] ^ ctsPrev;
  assign rxHigh    = (rxCount >= rxLvlQ);
  assign txLow     = (txCount <= txLvlQ);

  always_comb begin
    intSet = '0;
    intSet[INT_MODEM] = ctsChange & ctrlQ[CTRL_MSIE];
    intSet[INT_RX]    = rxHigh    & ctrlQ[CTRL_RXIE];
    intSet[INT_TX]    = txLow     & ctrlQ[CTRL_TXIE];
    intSet[INT_TMO]   = rxTimeout & ctrlQ[CTRL_TOIE];
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ  <= '0;
      ctrlQ  <= '0;
      rxLvlQ <= CNT_W'(RX_LVL_RST);
      txLvlQ <= CNT_W'(TX_LVL_RST);
    end else begin
      if (strb.wrLine)  lineQ  <= wdata[7:0] & LINE_WMASK;
      if (strb.wrCtrl)  ctrlQ  <= wdata[7:0] & CTRL_WMASK;
      if (strb.wrRxLvl) rxLvlQ <= wdata[CNT_W-1:0];
      if (strb.wrTxLvl) txLvlQ <= wdata[CNT_W-1:0];
    end
  end

  // Sticky error bits and pending interrupts; a write clear wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errStat <= '0;
      intPend <= '0;
    end else begin
      if (strb.wrStat) errStat <= '0;
      else             errStat <= errStat | errIn;
      if (strb.wrIntId) intPend <= '0;
      else              intPend <= intPend | intSet;
    end
  end

  assign flagsQ = {txCount == '0, rxCount == FULL_CNT, txCount == FULL_CNT,
                   rxCount == '0, busyIn, modemSync};
  assign irqOut = |intPend;
  assign txPush = strb.wrData;
  assign txData = wdata;
  assign rxPop  = strb.rdData;

endmodule

// File: rtl/serial_csr_top.sv
module serial_csr_top
  import serial_csr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic              rxPop,
  input  logic [DATA_W-1:0] rxData,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] rxCount,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] txCount,
  input  logic              errFrame,
  input  logic              errParity,
  input  logic              errBreak,
  input  logic              errOverrun,
  input  logic              rxTimeout,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              dcdIn,
  input  logic              busyIn,
  output logic              brkOut,
  output logic              parityEn,
  output logic              parityEven,
  output logic              twoStop,
  output logic              fifoEn,
  output logic [1:0]        wordLen,
  output logic              uartEn,
  output logic              loopback,
  output logic              irqOut
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  csrStrobe_t       strb;
  logic [7:0]       lineQ;
  logic [7:0]       ctrlQ;
  logic [3:0]       errStat;
  logic [7:0]       flagsQ;
  logic [3:0]       intPend;
  logic [CNT_W-1:0] rxLvlQ;
  logic [CNT_W-1:0] txLvlQ;

  serial_csr_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .rxData  (rxData),
    .lineQ   (lineQ),
    .ctrlQ   (ctrlQ),
    .errStat (errStat),
    .flagsQ  (flagsQ),
    .intPend (intPend),
    .rxLvlQ  (rxLvlQ),
    .txLvlQ  (txLvlQ),
    .strb    (strb),
    .busRdata(busRdata)
  );

  serial_csr_dp #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata),
    .rxCount  (rxCount),
    .txCount  (txCount),
    .errIn    ({errOverrun, errBreak, errParity, errFrame}),
    .rxTimeout(rxTimeout),
    .modemIn  ({dcdIn, dsrIn, ctsIn}),
    .busyIn   (busyIn),
    .lineQ    (lineQ),
    .ctrlQ    (ctrlQ),
    .errStat  (errStat),
    .flagsQ   (flagsQ),
    .intPend  (intPend),
    .rxLvlQ   (rxLvlQ),
    .txLvlQ   (txLvlQ),
    .irqOut   (irqOut),
    .txPush   (txPush),
    .txData   (txData),
    .rxPop    (rxPop)
  );

  assign brkOut     = lineQ[0];
  assign parityEn   = lineQ[1];
  assign parityEven = lineQ[2];
  assign twoStop    = lineQ[3];
  assign fifoEn     = lineQ[4];
  assign wordLen    = lineQ[6:5];
  assign uartEn     = ctrlQ[CTRL_EN];
  assign loopback   = ctrlQ[CTRL_LOOP];

endmodule

// File: rtl/serial_csr_chk.sv
module serial_csr_chk
  import serial_csr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       busAddr,
  input logic             busWe,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] txCount,
  input logic [7:0]       ctrlQ,
  input logic [CNT_W-1:0] rxLvlQ,
  input logic [CNT_W-1:0] txLvlQ,
  input logic [3:0]       intPend,
  input logic [3:0]       errStat
);

  logic clrInt;
  assign clrInt = busWe && (busAddr == ADDR_INTID);

  AST_STATUS_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    busWe && (busAddr == ADDR_STAT) |=> errStat == 4'h0); // R6

  AST_INTID_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    clrInt |=> intPend == 4'h0); // R12

  AST_RX_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    !clrInt && ctrlQ[CTRL_RXIE] && (rxCount >= rxLvlQ) |=> intPend[INT_RX]); // R7

  AST_TX_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    !clrInt && ctrlQ[CTRL_TXIE] && (txCount <= txLvlQ) |=> intPend[INT_TX]); // R8

  AST_TIMEOUT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPend[INT_TMO]) |-> $past(ctrlQ[CTRL_TOIE])); // R11

  AST_MODEM_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPend[INT_MODEM]) |-> $past(ctrlQ[CTRL_MSIE])); // R9

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrInt && intPend[INT_RX] |=> intPend[INT_RX]); // R12

endmodule

bind serial_csr_top serial_csr_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_serial_csr_top.sv
module test_serial_csr_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic       busRe = 1'b0;
  logic [7:0] busRdata;
  logic       txPush;
  logic [7:0] txData;
  logic       rxPop;
  logic [7:0] rxData = '0;
  logic [4:0] rxCount = '0;
  logic [4:0] txCount = '0;
  logic       errFrame = 0, errParity = 0, errBreak = 0, errOverrun = 0;
  logic       rxTimeout = 0, ctsIn = 0, dsrIn = 0, dcdIn = 0, busyIn = 0;
  logic       brkOut, parityEn, parityEven, twoStop, fifoEn, uartEn, loopback, irqOut;
  logic [1:0] wordLen;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_csr_top i_serial_csr_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(6'h08, v); chk("R1 line", v, 8'h00);
    rd(6'h14, v); chk("R1 ctrl", v, 8'h00);
    rd(6'h04, v); chk("R1 status", v, 8'h00);
    rd(6'h1C, v); chk("R1 pending", v, 8'h00);
    rd(6'h38, v); chk("R1 rx level", v, 8'h01);
    rd(6'h3C, v); chk("R1 tx level", v, 8'h00);
    chk("R1 irq", irqOut, 0);

    // R2 line control
    wr(6'h08, 8'hFF); rd(6'h08, v); chk("R2 line mask", v, 8'h7F);
    wr(6'h08, 8'h55);
    chk("R2 outputs", {wordLen, fifoEn, twoStop, parityEven, parityEn, brkOut}, 7'b10_1_0_1_0_1);
    wr(6'h08, 8'h2A);
    chk("R2 outputs2", {wordLen, fifoEn, twoStop, parityEven, parityEn, brkOut}, 7'b01_0_1_0_1_0);

    // R3 control
    wr(6'h14, 8'hFF); rd(6'h14, v); chk("R3 ctrl mask", v, 8'hF9);
    chk("R3 en/loop", {uartEn, loopback}, 2'b11);
    wr(6'h14, 8'h00); chk("R3 en/loop off", {uartEn, loopback}, 2'b00);

    // R4 data port
    busAddr = 6'h00; busWdata = 8'hA5; busWe = 1'b1;
    #1 chk("R4 txPush", {txPush, txData}, {1'b1, 8'hA5});
    @(posedge clk); @(negedge clk); busWe = 1'b0;
    #1 chk("R4 txPush low", txPush, 0);
    rxData = 8'h3C; busAddr = 6'h00; busRe = 1'b1;
    #1 chk("R4 rx read", {rxPop, busRdata}, {1'b1, 8'h3C});
    busAddr = 6'h18;
    #1 chk("R4 no pop", rxPop, 0);
    @(negedge clk); busRe = 1'b0;

    // R5 flags sweep over counts
    for (int c = 0; c <= 16; c++) begin
      rxCount = 5'(c); txCount = 5'(16 - c); busyIn = c[0];
      rd(6'h18, v);
      chk("R5 flags", v, {(16 - c) == 0, c == 16, (16 - c) == 16, c == 0, c[0], 3'b000});
    end
    busyIn = 0;
    dsrIn = 1; dcdIn = 1; tick(); tick();
    rd(6'h18, v); chk("R5 dsr/dcd", v[2:0], 3'b110);
    dsrIn = 0; dcdIn = 0; tick(); tick();

    // R6 error status
    errParity = 1; tick(); errParity = 0;
    rd(6'h04, v); chk("R6 parity", v, 8'h02);
    errBreak = 1; errOverrun = 1; tick(); errBreak = 0; errOverrun = 0;
    rd(6'h04, v); chk("R6 sticky", v, 8'h0E);
    wr(6'h04, 8'h00); rd(6'h04, v); chk("R6 clear", v, 8'h00);
    errFrame = 1; wr(6'h04, 8'hFF); errFrame = 0;
    rd(6'h04, v); chk("R6 clear wins", v, 8'h00);
    errFrame = 1; tick(); errFrame = 0;
    rd(6'h04, v); chk("R6 frame", v, 8'h01);
    wr(6'h04, 8'h00);

    // R7 receive threshold sweep; R12 clear then re-arm; R13 irq
    txCount = 5'd16;
    wr(6'h14, 8'h10);
    for (int l = 0; l <= 16; l++) begin
      for (int c = 0; c <= 16; c++) begin
        rxCount = 5'(c);
        wr(6'h38, 8'(l));
        wr(6'h1C, 8'h00);
        rd(6'h1C, v); chk("R12 cleared", v, 8'h00);
        rd(6'h1C, v); chk("R7 rx level", v, {6'b0, c >= l, 1'b0});
        chk("R13 irq", irqOut, c >= l);
      end
    end

    // R8 transmit threshold sweep
    rxCount = 5'd0;
    wr(6'h14, 8'h20);
    for (int k = 0; k < 3; k++) begin
      automatic int l = (k == 0) ? 0 : (k == 1) ? 5 : 16;
      for (int c = 0; c <= 16; c++) begin
        txCount = 5'(c);
        wr(6'h3C, 8'(l));
        wr(6'h1C, 8'h00);
        tick();
        rd(6'h1C, v); chk("R8 tx level", v, {5'b0, c <= l, 2'b00});
      end
    end

    // R11 gating: disabled enables ignore events
    txCount = 5'd16; rxCount = 5'd0;
    wr(6'h14, 8'h00); wr(6'h1C, 8'h00);
    rxTimeout = 1; tick(); rxTimeout = 0;
    ctsIn = 1; tick(); tick(); tick();
    rd(6'h1C, v); chk("R11 no pend", v, 8'h00);
    wr(6'h14, 8'h48); tick();
    rd(6'h1C, v); chk("R11 no late set", v, 8'h00);
    chk("R11 irq low", irqOut, 0);

    // R10 timeout
    rxTimeout = 1; tick(); rxTimeout = 0;
    rd(6'h1C, v); chk("R10 timeout", v, 8'h08);
    chk("R13 irq tmo", irqOut, 1);
    wr(6'h1C, 8'h5A); tick();
    rd(6'h1C, v); chk("R12 pulse stays clear", v, 8'h00);
    chk("R13 irq clear", irqOut, 0);

    // R9 modem change with synchroniser timing
    wr(6'h14, 8'h08); wr(6'h1C, 8'h00);
    ctsIn = 0;
    @(negedge clk);
    rd(6'h18, v); chk("R9 cts not yet", v[0], 1);
    rd(6'h18, v); chk("R9 cts synced", v[0], 0);
    rd(6'h1C, v); chk("R9 modem pend", v, 8'h01);
    wr(6'h1C, 8'h00); tick();
    rd(6'h1C, v); chk("R9 one event", v, 8'h00);

    // R14 unmapped addresses
    wr(6'h0C, 8'hFF); wr(6'h2C, 8'hFF);
    rd(6'h0C, v); chk("R14 read zero", v, 8'h00);
    rd(6'h08, v); chk("R14 line kept", v, 8'h2A);
    rd(6'h14, v); chk("R14 ctrl kept", v, 8'h08);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule